// File: doc/BRIEF.md
# Interrupt enable and flag register

This block is an 8-bit register on the processor's data bus. It gathers the interrupt state for three event sources: a timer overflow, an edge on an external pin and a change on an input port. Each source has an enable bit and a flag bit. The register also holds a peripheral enable and a master enable. Each source delivers a pulse one clock wide. That pulse latches the source's flag whatever the enables hold. The block then drives one level-sensitive interrupt request to the core, and the request follows the flags, the enables and a separate request input from the peripherals.

Software reads and writes the register at either of two mirrored bus addresses, so it can reach the register from either bank. Writes take effect on the clock edge. Reads are combinational from the selected address. A flag clears only when software writes it to 0. If a hardware event arrives in the same cycle as that write, the event wins. A flag that latched while its source was masked raises the request as soon as software enables the source.

Top module: `irq_ctrl_reg`

## Requirements
- R1: The register reads back, combinationally, on rdata_o at both 0x0B and 0x8B. Its layout from bit 7 down to bit 0 is: master enable, peripheral enable, timer enable, pin enable, port enable, timer flag, pin flag, port flag.
- R2: Reset (rst_ni low) clears all eight bits to 0, and irq_o is 0.
- R3: A pulse on tmr_ovf_i, ext_evt_i or port_chg_i sets flag bit 2, 1 or 0 respectively at the next clock edge, whatever the enable bits hold.
- R4: Every bit is writable through wr_en_i at a mirrored address. A flag holds its value until software writes it, and writing 1 sets it.
- R5: When a software write of 0 to a flag and that flag's event fall in the same cycle, the flag ends up set.
- R6: While the master enable (bit 7) is 0, irq_o is 0.
- R7: With the master enable set, irq_o is 1 when any source has both its enable and its flag set (timer 5/2, pin 4/1, port 3/0).
- R8: periph_req_i raises irq_o only when both the peripheral enable (bit 6) and the master enable are 1.
- R9: A write to any address other than the two mirrors leaves the register unchanged. A read from such an address returns 0.
- R10: A flag left pending while masked raises irq_o in the cycle after software writes its enable and the master enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Bus address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 unless a mirror address is selected |
| tmr_ovf_i | input | 1 | Timer rollover pulse |
| ext_evt_i | input | 1 | External pin edge pulse |
| port_chg_i | input | 1 | Port change pulse |
| periph_req_i | input | 1 | Combined request from the peripherals |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The bench builds the block with its default parameters: an 8-bit address with mirrors at 0x0B and 0x8B. With these it can write through one mirror and read back through the other, and it can probe an unmapped address such as 0x40. The tests latch flags while every source is masked and then enable the sources one at a time, so each gating term of the request is checked on its own. They also drive an event and a clearing write in the same cycle, and they vary the peripheral request against both enables.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NUM_SRC  = 3;
  localparam int REG_W    = 2 + 2 * NUM_SRC;
  localparam int FLAG_LSB = 0;
  localparam int EN_LSB   = FLAG_LSB + NUM_SRC;
  localparam int PEN_BIT  = EN_LSB + NUM_SRC;
  localparam int GEN_BIT  = PEN_BIT + 1;
  // source index = flag bit offset
  localparam int SRC_PORT = 0;
  localparam int SRC_PIN  = 1;
  localparam int SRC_TMR  = 2;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec #(
  parameter int ADDR_W = 8,
  parameter int NUM_MIRROR = 2,
  parameter logic [NUM_MIRROR-1:0][ADDR_W-1:0] MIRROR_ADDRS = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sel_o
);
  logic [NUM_MIRROR-1:0] hit;
  for (genvar m = 0; m < NUM_MIRROR; m++) begin : g_mirror
    assign hit[m] = (addr_i == MIRROR_ADDRS[m]);
  end
  assign sel_o = |hit;
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic q_o
);
  // hardware set has priority over a software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (wr_i)   q_o <= wbit_i;
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int NUM_SRC = 3
) (
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic               glb_en_i,
  input  logic               per_en_i,
  input  logic               per_req_i,
  output logic               irq_o
);
  logic src_any;
  assign src_any = |(en_i & flag_i);
  assign irq_o   = glb_en_i & (src_any | (per_en_i & per_req_i));
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BANK0_ADDR = 8'h0B,
  parameter logic [ADDR_W-1:0] BANK1_ADDR = 8'h8B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              tmr_ovf_i,
  input  logic              ext_evt_i,
  input  logic              port_chg_i,
  input  logic              periph_req_i,
  output logic              irq_o
);
  localparam int NUM_MIRROR = 2;

  logic                 sel;
  logic                 reg_wr;
  logic [NUM_SRC-1:0]   evt;
  logic [NUM_SRC-1:0]   flag_q;
  logic [NUM_SRC-1:0]   en_q;
  logic                 gen_q;
  logic                 pen_q;
  logic [REG_W-1:0]     reg_q;

  irq_addr_dec #(
    .ADDR_W      (ADDR_W),
    .NUM_MIRROR  (NUM_MIRROR),
    .MIRROR_ADDRS({BANK1_ADDR, BANK0_ADDR})
  ) u_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  assign reg_wr = wr_en_i & sel;

  always_comb begin
    evt           = '0;
    evt[SRC_TMR]  = tmr_ovf_i;
    evt[SRC_PIN]  = ext_evt_i;
    evt[SRC_PORT] = port_chg_i;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
    irq_flag_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (evt[s]),
      .wr_i  (reg_wr),
      .wbit_i(wdata_i[FLAG_LSB+s]),
      .q_o   (flag_q[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      pen_q <= 1'b0;
      gen_q <= 1'b0;
    end else if (reg_wr) begin
      en_q  <= wdata_i[EN_LSB +: NUM_SRC];
      pen_q <= wdata_i[PEN_BIT];
      gen_q <= wdata_i[GEN_BIT];
    end
  end

  assign reg_q   = {gen_q, pen_q, en_q, flag_q};
  assign rdata_o = sel ? reg_q : '0;

  irq_req_gen #(.NUM_SRC(NUM_SRC)) u_req (
    .en_i     (en_q),
    .flag_i   (flag_q),
    .glb_en_i (gen_q),
    .per_en_i (pen_q),
    .per_req_i(periph_req_i),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/irq_ctrl_reg_chk.sv
module irq_ctrl_reg_chk
  import irq_ctrl_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wdata_i,
  input logic [REG_W-1:0] rdata_o,
  input logic             tmr_ovf_i,
  input logic             ext_evt_i,
  input logic             port_chg_i,
  input logic             periph_req_i,
  input logic             irq_o,
  input logic             sel,
  input logic [REG_W-1:0] reg_q
);
  logic any_evt;
  assign any_evt = tmr_ovf_i | ext_evt_i | port_chg_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R2: assert (reg_q == '0 && !irq_o);
    end
  end

  assert_tmr_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_i |=> reg_q[FLAG_LSB+SRC_TMR]);

  assert_port_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_chg_i |=> reg_q[FLAG_LSB+SRC_PORT]);

  assert_flag_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_q[FLAG_LSB+SRC_PORT] && !(wr_en_i && sel)) |=> reg_q[FLAG_LSB+SRC_PORT]);

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel && !wdata_i[FLAG_LSB+SRC_PIN] && ext_evt_i) |=> reg_q[FLAG_LSB+SRC_PIN]);

  assert_gen_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_q[GEN_BIT] |-> !irq_o);

  assert_periph_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_q[GEN_BIT] && reg_q[PEN_BIT] && periph_req_i) |-> irq_o);

  assert_foreign_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !sel && !any_evt) |=> $stable(reg_q));

  assert_foreign_rd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |-> (rdata_o == '0));
endmodule

bind irq_ctrl_reg irq_ctrl_reg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .tmr_ovf_i   (tmr_ovf_i),
  .ext_evt_i   (ext_evt_i),
  .port_chg_i  (port_chg_i),
  .periph_req_i(periph_req_i),
  .irq_o       (irq_o),
  .sel         (sel),
  .reg_q       (reg_q)
);

// File: tb/irq_ctrl_reg_tb.sv
module irq_ctrl_reg_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] addr_i;
  logic       wr_en_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;
  logic       tmr_ovf_i, ext_evt_i, port_chg_i, periph_req_i;
  logic       irq_o;

  always #2.5 clk_i = ~clk_i;

  irq_ctrl_reg u_dut (.*);

  typedef struct {
    string      rq;
    logic [7:0] rd;
    logic       irq;
  } exp_t;

  exp_t       sb_q[$];
  int         n_vec  = 0;
  int         n_fail = 0;
  logic [7:0] m      = 8'h00;
  logic       preq   = 1'b0;
  bit         done   = 0;

  function automatic logic model_irq(logic [7:0] r, logic p);
    return r[7] & ((r[5] & r[2]) | (r[4] & r[1]) | (r[3] & r[0]) | (r[6] & p));
  endfunction

  // monitor: pop and compare against ports
  initial begin
    forever begin
      exp_t it;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      n_vec++;
      if (rdata_o !== it.rd || irq_o !== it.irq) begin
        n_fail++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 it.rq, rdata_o, irq_o, it.rd, it.irq);
      end
    end
  end

  task automatic push(string rq, logic [7:0] rd, logic irq);
    exp_t it;
    #1;
    it.rq = rq; it.rd = rd; it.irq = irq;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic probe(string rq, logic [7:0] a, logic [7:0] exp_rd);
    @(negedge clk_i);
    addr_i = a;
    push(rq, exp_rd, model_irq(m, preq));
  endtask

  // ev = {tmr, pin, port}
  task automatic step(string rq, logic [7:0] a, logic wr, logic [7:0] wd,
                      logic [2:0] ev, logic p);
    @(negedge clk_i);
    addr_i = a; wr_en_i = wr; wdata_i = wd;
    {tmr_ovf_i, ext_evt_i, port_chg_i} = ev;
    periph_req_i = p; preq = p;
    @(posedge clk_i);
    if (wr && (a == 8'h0B || a == 8'h8B)) m = wd;
    m[2:0] = m[2:0] | ev;
    @(negedge clk_i);
    wr_en_i = 1'b0; {tmr_ovf_i, ext_evt_i, port_chg_i} = 3'b000;
    addr_i = 8'h0B;
    push(rq, m, model_irq(m, preq));
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    addr_i = 8'h0B; wr_en_i = 1'b0; wdata_i = 8'h00;
    tmr_ovf_i = 1'b0; ext_evt_i = 1'b0; port_chg_i = 1'b0; periph_req_i = 1'b0;
    repeat (3) @(posedge clk_i);
    probe("R2 in reset", 8'h0B, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
    probe("R2 after reset", 8'h0B, 8'h00);

    // R3: flags latch with everything masked
    step("R3 timer flag", 8'h0B, 0, 8'h00, 3'b100, 0);
    step("R3 pin flag",   8'h0B, 0, 8'h00, 3'b010, 0);
    step("R3 port flag",  8'h0B, 0, 8'h00, 3'b001, 0);
    step("R4 flags hold", 8'h0B, 0, 8'h00, 3'b000, 0);
    probe("R1 mirror read 0x8B", 8'h8B, 8'h07);

    // R10: enable after pending
    step("R10 late enable timer", 8'h0B, 1, 8'hA7, 3'b000, 0);

    // R9: foreign address
    step("R9 foreign write", 8'h40, 1, 8'h00, 3'b000, 0);
    probe("R9 foreign read", 8'h40, 8'h00);

    // R5: clear and event same cycle
    step("R5 set wins over clear", 8'h8B, 1, 8'h80, 3'b100, 0);
    step("R4 clear flags", 8'h0B, 1, 8'h00, 3'b000, 0);
    step("R4 write ones", 8'h8B, 1, 8'h5A, 3'b000, 0);
    step("R4 write zero", 8'h0B, 1, 8'h00, 3'b000, 0);

    // R6: master enable off
    step("R6 master off", 8'h0B, 1, 8'h3F, 3'b000, 1);

    // R7: per-source gating
    step("R7 pin source",        8'h0B, 1, 8'h92, 3'b000, 0);
    step("R7 port en, pin flag", 8'h0B, 1, 8'h8A, 3'b000, 0);
    step("R7 port source",       8'h0B, 1, 8'h89, 3'b000, 0);
    step("R7 timer en only",     8'h0B, 1, 8'hA0, 3'b000, 0);

    // R8: peripheral request
    step("R8 periph no master",  8'h0B, 1, 8'h40, 3'b000, 1);
    step("R8 periph enabled",    8'h0B, 1, 8'hC0, 3'b000, 1);
    step("R8 periph req low",    8'h0B, 0, 8'h00, 3'b000, 0);
    step("R8 periph en off",     8'h0B, 1, 8'h80, 3'b000, 1);

    // R10: port flag via event while masked, then enable
    step("R10 port event masked", 8'h0B, 0, 8'h00, 3'b001, 0);
    step("R10 enable port",       8'h8B, 1, 8'h89, 3'b000, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule